// File: doc/BRIEF.md
# Flash Bank Chip-Erase Controller

This block models the command front end and the internal erase engine of one parallel NOR-style flash bank. It watches host write strobes. When it sees one exact six-write sequence, it starts a self-timed chip erase. Writes that do not follow that sequence leave the bank untouched. The array is a small bank of registers that the host reads by address.

The erase runs in two timed phases with no help from the host. The first phase forces every word to zero. The second phase sets every word to all ones. While the engine works, the ready output is low and every read returns a status word instead of array data. In that status word, two bits flip on each read, so software can poll for progress. An asynchronous reset stops the erase at once and returns the bank to plain read mode.

Top module: `nor_erase_ctl`

## Requirements
- R1: The erase starts only after six write strobes in this order: 0xAA at 0x555, 0x55 at 0x2AA, 0x80 at 0x555, 0xAA at 0x555, 0x55 at 0x2AA, 0x10 at 0x555. The upper data byte must be zero in each write. ready goes low in the cycle after the clock edge that captures the sixth write.
- R2: A write that does not match the next expected step, in address or in data, sends the decoder back to the first step. The interrupted sequence must then be restarted from the beginning.
- R3: ready stays low for exactly PRE_CYC + ERS_CYC clock cycles and then returns high.
- R4: While ready is low, rdata is a status word for any address. Bit 7 reads 0. Every bit other than 6 and 2 reads 0.
- R5: While ready is low, bits 6 and 2 of the status word are equal. The first read after the erase starts returns them as 0, and each read strobe inverts them for the next read (0x0000, 0x0044, 0x0000, and so on).
- R6: Writes made while ready is low have no effect. A partial sequence written during the erase does not carry over past the end of the erase.
- R7: When ready returns high, rdata shows the array word at addr[IDX_W-1:0] with no further latching, and every word reads all ones.
- R8: The first phase writes zero to every word. An erase stopped by reset after that phase leaves every word reading 0x0000.
- R9: rst_n low forces ready high at once and clears the decoder. After reset, rdata shows array data and a lone 0x10 write does not start an erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Stops any running erase. |
| we | input | 1 | Host write strobe, one cycle per write |
| re | input | 1 | Host read strobe. Advances the status toggle while the bank is busy. |
| addr | input | ADDR_W | Word address for writes and reads |
| wdata | input | DATA_W | Write data. Commands use the low byte. |
| rdata | output | DATA_W | Array word in read mode, status word while busy |
| ready | output | 1 | High when idle, low while the erase is running |

## Verification
The assertions assume that each host write or read is a single-cycle strobe sampled on the rising clock edge. They also assume that reads while busy are counted per cycle that re is high, and that rst_n, when it is used, is held low for at least one clock edge. The stimulus drives every strobe for exactly one cycle, changing it on the falling edge. It never raises we and re in the same cycle, and it holds reset low for a full cycle. Because of this, toggle counting and sequence detection see each host access exactly once.

// File: rtl/nor_erase_ctl.sv
module nor_erase_ctl #(
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 16,
  parameter int PRE_CYC = 24,
  parameter int ERS_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ready
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int MAXC  = (PRE_CYC > ERS_CYC) ? PRE_CYC : ERS_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(12'h2AA);

  logic [2:0]        step;
  logic              busy, erase_ph, tog;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] exp_a;
  logic [7:0]        exp_d;
  logic [DATA_W-1:0] mem [DEPTH];

  always_comb begin
    unique case (step)
      3'd0:    begin exp_a = A_HI; exp_d = 8'hAA; end
      3'd1:    begin exp_a = A_LO; exp_d = 8'h55; end
      3'd2:    begin exp_a = A_HI; exp_d = 8'h80; end
      3'd3:    begin exp_a = A_HI; exp_d = 8'hAA; end
      3'd4:    begin exp_a = A_LO; exp_d = 8'h55; end
      default: begin exp_a = A_HI; exp_d = 8'h10; end
    endcase
  end

  wire hit = (addr == exp_a) && (wdata == {{(DATA_W-8){1'b0}}, exp_d});
  wire [CNT_W-1:0] ph_end = erase_ph ? CNT_W'(ERS_CYC - 1) : CNT_W'(PRE_CYC - 1);
  wire ph_done = busy && (cnt == ph_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step     <= '0;
      busy     <= 1'b0;
      erase_ph <= 1'b0;
      cnt      <= '0;
      tog      <= 1'b0;
    end else if (busy) begin
      if (re) tog <= ~tog;
      if (ph_done) begin
        cnt      <= '0;
        erase_ph <= 1'b1;
        if (erase_ph) busy <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (we) begin
      if (!hit) begin
        step <= '0;
      end else if (step == 3'd5) begin
        step     <= '0;
        busy     <= 1'b1;
        erase_ph <= 1'b0;
        cnt      <= '0;
        tog      <= 1'b0;
      end else begin
        step <= step + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ph_done)
      for (int i = 0; i < DEPTH; i++) mem[i] <= erase_ph ? {DATA_W{1'b1}} : {DATA_W{1'b0}};
  end

  logic [DATA_W-1:0] stat;
  always_comb begin
    stat    = '0;
    stat[6] = tog;
    stat[2] = tog;
  end

  assign rdata = busy ? stat : mem[addr[IDX_W-1:0]];
  assign ready = ~busy;
endmodule

// File: rtl/nor_erase_ctl_chk.sv
module nor_erase_ctl_chk #(
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 16,
  parameter int PRE_CYC = 24,
  parameter int ERS_CYC = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              we,
  input logic              re,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              ready
);
  logic [31:0] low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     low_cnt <= '0;
    else if (ready) low_cnt <= '0;
    else            low_cnt <= low_cnt + 1;
  end

  AST_START_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(we && addr == ADDR_W'(12'h555) && wdata[7:0] == 8'h10)); // R1

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> low_cnt < 32'(PRE_CYC + ERS_CYC)); // R3

  AST_STATUS_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (rdata[7] == 1'b0 && rdata[6] == rdata[2] && (rdata & ~DATA_W'(16'h0044)) == '0)); // R4

  AST_STATUS_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(re) && $past(!ready) && !ready) |-> rdata[6] != $past(rdata[6])); // R5

  AST_DONE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> rdata == {DATA_W{1'b1}}); // R7
endmodule

bind nor_erase_ctl nor_erase_ctl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_CYC(PRE_CYC), .ERS_CYC(ERS_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .re(re), .addr(addr),
  .wdata(wdata), .rdata(rdata), .ready(ready)
);

// File: tb/sim_nor_erase_ctl.sv
`timescale 1ns/1ps
module sim_nor_erase_ctl;
  localparam int ADDR_W = 11, DATA_W = 16, PRE_CYC = 24, ERS_CYC = 40;

  logic clk = 1'b0;
  logic rst_n, we, re;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, rdata;
  logic ready;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  nor_erase_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_CYC(PRE_CYC), .ERS_CYC(ERS_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .we(we), .re(re), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ready(ready));

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, logic [15:0] e, string tag);
    @(negedge clk); addr = a; re = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); re = 1'b0;
  endtask

  task automatic seq5();
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0080);
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055);
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk); #2;
      if (re) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL monitor: actual read with no expected item, expected queued item");
        end else begin
          logic [15:0] e; string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          if (rdata !== e) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", t, rdata, e);
          end
        end
      end
    end
  end

  initial begin
    #(8ns * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int k;
    rst_n = 1'b0; we = 1'b0; re = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset ready", 16'(ready), 16'd1);
    rst_n = 1'b1;

    // R2: bad setup byte, then tail of sequence
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0090);
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0010);
    repeat (2) @(negedge clk);
    chk("R2 bad setup no erase", 16'(ready), 16'd1);
    // R2: wrong final command, then lone final command
    seq5(); wr(11'h555, 16'h0030); wr(11'h555, 16'h0010);
    chk("R2 bad command no erase", 16'(ready), 16'd1);
    // R2: upper data byte nonzero
    seq5(); wr(11'h555, 16'h0110);
    chk("R2 upper byte no erase", 16'(ready), 16'd1);

    // R1, R3
    seq5(); wr(11'h555, 16'h0010);
    #1 chk("R1 ready low after sixth write", 16'(ready), 16'd0);
    k = 0;
    while (!ready) begin @(negedge clk); k++; end
    chk("R3 busy length", 16'(k), 16'(PRE_CYC + ERS_CYC));
    rd(11'h000, 16'hFFFF, "R7 word 0");
    rd(11'h007, 16'hFFFF, "R7 word 7");
    rd(11'h00F, 16'hFFFF, "R7 word 15");

    // R4, R5, R6
    seq5(); wr(11'h555, 16'h0010);
    rd(11'h003, 16'h0000, "R5 first status read");
    rd(11'h00A, 16'h0044, "R5 second status read");
    rd(11'h555, 16'h0000, "R4 third status read");
    rd(11'h001, 16'h0044, "R5 fourth status read");
    seq5();
    chk("R6 still busy after writes", 16'(ready), 16'd0);
    wait_ready();
    wr(11'h555, 16'h0010);
    repeat (2) @(negedge clk);
    chk("R6 partial sequence discarded", 16'(ready), 16'd1);

    // R8, R9: abort in erase phase
    seq5(); wr(11'h555, 16'h0010);
    repeat (PRE_CYC + 2) @(negedge clk);
    rd(11'h002, 16'h0000, "R4 status in erase phase");
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R9 ready high at reset", 16'(ready), 16'd1);
    @(negedge clk); rst_n = 1'b1;
    rd(11'h005, 16'h0000, "R8 word 5 zeroed");
    rd(11'h00C, 16'h0000, "R8 word 12 zeroed");
    rd(11'h00C, 16'h0000, "R9 read mode stable");
    wr(11'h555, 16'h0010);
    chk("R9 decoder idle after reset", 16'(ready), 16'd1);

    seq5(); wr(11'h555, 16'h0010);
    wait_ready();
    rd(11'h009, 16'hFFFF, "R7 erase after abort");

    repeat (2) @(negedge clk);
    chk("monitor queue drained", 16'(exp_q.size()), 16'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule